// File: doc/BRIEF.md
# Signed Peak Hold Monitor

This block follows three sample streams and remembers, for each one, the most extreme sample seen since the last clear. Two streams are signed 14-bit acceleration axes. For these, the block keeps the sample with the largest absolute value, and the stored value keeps that sample's sign. The third stream is an unsigned 14-bit combined-magnitude value, for which the block keeps a plain unsigned maximum.

Each held value is presented in its own 16-bit status word:

- bit 15 is a new-data flag, set when the held value changes and cleared by a per-channel read strobe;
- bit 14 copies an external alarm/error input;
- bits 13:0 hold the value, in two's complement for the axes and unsigned for the combined channel.

A sample is taken only when the valid strobe is high. A one-cycle clear command zeroes every held value and every flag. Held values keep building up no matter how often they are read.

Top module: `peak_hold_monitor`

## Requirements
- R1: On a valid sample, an axis channel replaces its held value only when the absolute value of the new sample is strictly greater than the absolute value of the held one. The stored value keeps the sample's sign in two's complement in bits 13:0, one cycle after the sample.
- R2: The combined channel (word from `magWord`) holds the unsigned maximum of all valid samples since the last clear. It never decreases except on a clear.
- R3: The most negative axis code (-8192, bits 13:0 = 0x2000) counts as magnitude 8192, larger than +8191. Once held, no other sample replaces it.
- R4: A sample whose magnitude equals the held magnitude, with either sign, leaves the held value and its new-data flag unchanged.
- R5: While `sampleValid` is 0, sample inputs have no effect on any held value or flag.
- R6: `clearPeaks` high for one cycle sets bits 15 and 13:0 of all three words to zero on the next cycle. A valid sample in the same cycle is discarded.
- R7: Bit 15 of a word goes to 1 in the cycle after its held value changes. It goes to 0 the cycle after the channel's read strobe, unless the held value changes in that same cycle, in which case it stays 1.
- R8: Bit 14 of every word equals `alarmIn` combinationally, with no clock edge needed.
- R9: After reset, bits 15 and 13:0 of all words are zero.
- R10: `readStrobe` bit 0 serves `axisAWord`, bit 1 `axisBWord`, bit 2 `magWord`. A read strobe affects only its own flag and never changes a held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Sample inputs are valid this cycle |
| axisASample | input | 14 | Signed axis A sample |
| axisBSample | input | 14 | Signed axis B sample |
| magSample | input | 14 | Unsigned combined-magnitude sample |
| clearPeaks | input | 1 | Clear all held values and flags |
| readStrobe | input | 3 | Per-channel read acknowledge |
| alarmIn | input | 1 | External alarm/error flag |
| axisAWord | output | 16 | Axis A status word |
| axisBWord | output | 16 | Axis B status word |
| magWord | output | 16 | Combined channel status word |

## Verification
A wrong magnitude compare shows in the data bits one cycle after the sample that should, or should not, have replaced the held value. The most negative code and equal-magnitude samples of opposite sign are the inputs that expose it. A flag register that is wrong shows in bit 15 one cycle after a read strobe or an update. The read-plus-update collision and reads on one channel while the others stay flagged make such faults visible. A bad clear priority shows as nonzero data on the cycle right after a clear that came with a valid sample.

// File: rtl/peak_pkg.sv
package peak_pkg;
  localparam int NUM_CH   = 3;
  localparam int NUM_AXES = 2;

  typedef struct packed {
    logic              captureEn;
    logic              clearAll;
    logic [NUM_CH-1:0] readAck;
  } peak_strobe_t;
endpackage

// File: rtl/peak_channel.sv
module peak_channel #(
  parameter int DATA_W    = 14,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              captureEn,
  input  logic              clearAll,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] held,
  output logic              grew
);
  localparam logic [DATA_W:0] ONE = {{DATA_W{1'b0}}, 1'b1};

  logic [DATA_W:0] sampleMag;
  logic [DATA_W:0] heldMag;

  generate
    if (IS_SIGNED) begin : gSigned
      // one extra bit so the most negative code maps to a positive magnitude
      assign sampleMag = sample[DATA_W-1] ? (~{1'b1, sample} + ONE) : {1'b0, sample};
      assign heldMag   = held[DATA_W-1]   ? (~{1'b1, held} + ONE)   : {1'b0, held};
    end else begin : gUnsigned
      assign sampleMag = {1'b0, sample};
      assign heldMag   = {1'b0, held};
    end
  endgenerate

  // strict compare: ties keep the stored value
  assign grew = captureEn && (sampleMag > heldMag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held <= '0;
    else if (clearAll) held <= '0;
    else if (grew)     held <= sample;
  end
endmodule

// File: rtl/peak_datapath.sv
module peak_datapath
  import peak_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  peak_strobe_t                   strobe,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  samples,
  output logic [NUM_CH-1:0][DATA_W-1:0]  heldVals,
  output logic [NUM_CH-1:0]              grew
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    peak_channel #(
      .DATA_W   (DATA_W),
      .IS_SIGNED(ch < NUM_AXES)
    ) uChan (
      .clk      (clk),
      .rst_n    (rst_n),
      .captureEn(strobe.captureEn),
      .clearAll (strobe.clearAll),
      .sample   (samples[ch]),
      .held     (heldVals[ch]),
      .grew     (grew[ch])
    );
  end
endmodule

// File: rtl/peak_ctrl.sv
module peak_ctrl
  import peak_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleValid,
  input  logic              clearPeaks,
  input  logic [NUM_CH-1:0] readStrobe,
  input  logic [NUM_CH-1:0] grew,
  output peak_strobe_t      strobe,
  output logic [NUM_CH-1:0] newData
);
  always_comb begin
    strobe.clearAll  = clearPeaks;
    strobe.captureEn = sampleValid && !clearPeaks;
    strobe.readAck   = readStrobe;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gFlag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      newData[ch] <= 1'b0;
      else if (strobe.clearAll)        newData[ch] <= 1'b0;
      else if (grew[ch])               newData[ch] <= 1'b1;
      else if (strobe.readAck[ch])     newData[ch] <= 1'b0;
    end
  end
endmodule

// File: rtl/peak_hold_monitor.sv
module peak_hold_monitor
  import peak_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] axisASample,
  input  logic [DATA_W-1:0] axisBSample,
  input  logic [DATA_W-1:0] magSample,
  input  logic              clearPeaks,
  input  logic [NUM_CH-1:0] readStrobe,
  input  logic              alarmIn,
  output logic [DATA_W+1:0] axisAWord,
  output logic [DATA_W+1:0] axisBWord,
  output logic [DATA_W+1:0] magWord
);
  peak_strobe_t                  strobe;
  logic [NUM_CH-1:0][DATA_W-1:0] samples;
  logic [NUM_CH-1:0][DATA_W-1:0] heldVals;
  logic [NUM_CH-1:0]             grew;
  logic [NUM_CH-1:0]             newData;

  assign samples = {magSample, axisBSample, axisASample};

  peak_ctrl uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .clearPeaks (clearPeaks),
    .readStrobe (readStrobe),
    .grew       (grew),
    .strobe     (strobe),
    .newData    (newData)
  );

  peak_datapath #(.DATA_W(DATA_W)) uPath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .samples (samples),
    .heldVals(heldVals),
    .grew    (grew)
  );

  assign axisAWord = {newData[0], alarmIn, heldVals[0]};
  assign axisBWord = {newData[1], alarmIn, heldVals[1]};
  assign magWord   = {newData[2], alarmIn, heldVals[2]};
endmodule

// File: rtl/peak_hold_checker.sv
module peak_hold_checker #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sampleValid,
  input logic [DATA_W-1:0] axisASample,
  input logic [DATA_W-1:0] axisBSample,
  input logic [DATA_W-1:0] magSample,
  input logic              clearPeaks,
  input logic [2:0]        readStrobe,
  input logic              alarmIn,
  input logic [DATA_W+1:0] axisAWord,
  input logic [DATA_W+1:0] axisBWord,
  input logic [DATA_W+1:0] magWord
);
  logic [3*DATA_W-1:0] allData;
  assign allData = {axisAWord[DATA_W-1:0], axisBWord[DATA_W-1:0], magWord[DATA_W-1:0]};

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clearPeaks |=> (allData == '0) && !axisAWord[DATA_W+1] && !axisBWord[DATA_W+1] && !magWord[DATA_W+1]); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleValid && !clearPeaks) |=> $stable(allData)); // R5

  AST_MAG_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !clearPeaks |=> magWord[DATA_W-1:0] >= $past(magWord[DATA_W-1:0])); // R2

  AST_READ_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (readStrobe[0] && !sampleValid) |=> !axisAWord[DATA_W+1]); // R7

  AST_CHANGE_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !clearPeaks |=> ((axisBWord[DATA_W-1:0] == $past(axisBWord[DATA_W-1:0])) || axisBWord[DATA_W+1])); // R7

  AST_ALARM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (axisAWord[DATA_W] == alarmIn) && (axisBWord[DATA_W] == alarmIn) && (magWord[DATA_W] == alarmIn)); // R8

  AST_OTHER_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (readStrobe == 3'b001 && !clearPeaks && magWord[DATA_W+1]) |=> magWord[DATA_W+1]); // R10
endmodule

bind peak_hold_monitor peak_hold_checker #(.DATA_W(DATA_W)) uChk (.*);

// File: tb/tb_peak_hold_monitor.sv
`timescale 1ns/1ps
module tb_peak_hold_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic [13:0] axisASample = '0;
  logic [13:0] axisBSample = '0;
  logic [13:0] magSample = '0;
  logic        clearPeaks = 1'b0;
  logic [2:0]  readStrobe = '0;
  logic        alarmIn = 1'b0;
  logic [15:0] axisAWord, axisBWord, magWord;

  int checks = 0;
  int errors = 0;

  peak_hold_monitor dut (.*);

  always #2 clk = ~clk;

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive for one clock, then return 1 ns after the edge with inputs idle
  task automatic step(logic v, logic [13:0] a, logic [13:0] b, logic [13:0] m,
                      logic clr, logic [2:0] rd);
    sampleValid = v; axisASample = a; axisBSample = b; magSample = m;
    clearPeaks = clr; readStrobe = rd;
    @(posedge clk); #1;
    sampleValid = 0; clearPeaks = 0; readStrobe = '0;
  endtask

  task automatic t_reset();
    chk("R9 axisA", axisAWord, 16'h0000);
    chk("R9 axisB", axisBWord, 16'h0000);
    chk("R9 mag",   magWord,   16'h0000);
  endtask

  task automatic t_signed();
    step(1, 14'd100, -14'sd50, 14'd30, 0, 3'b000);
    chk("R1 axisA positive", axisAWord, 16'h8064);
    chk("R1 axisB negative", axisBWord, 16'hBFCE);
    chk("R2 mag first",      magWord,   16'h801E);
    step(1, -14'sd200, -14'sd10, 14'd5, 0, 3'b000);
    chk("R1 axisA larger negative", axisAWord, 16'hBF38);
    chk("R1 axisB smaller kept",    axisBWord, 16'hBFCE);
    step(1, 14'd150, 14'd49, 14'd29, 0, 3'b000);
    chk("R1 axisA smaller positive kept", axisAWord, 16'hBF38);
  endtask

  task automatic t_tie();
    step(0, 0, 0, 0, 0, 3'b111);
    chk("R7 read clears A flag", axisAWord, 16'h3F38);
    step(1, 14'd200, 14'd50, 14'd30, 0, 3'b000);
    chk("R4 axisA tie opposite sign", axisAWord, 16'h3F38);
    chk("R4 axisB tie opposite sign", axisBWord, 16'h3FCE);
    chk("R4 mag tie",                 magWord,   16'h001E);
  endtask

  task automatic t_valid();
    step(0, 14'd8000, 14'd8000, 14'd16000, 0, 3'b000);
    chk("R5 axisA ignored", axisAWord, 16'h3F38);
    chk("R5 axisB ignored", axisBWord, 16'h3FCE);
    chk("R5 mag ignored",   magWord,   16'h001E);
  endtask

  task automatic t_mostneg();
    step(1, 14'h2000, 0, 0, 0, 3'b000);
    chk("R3 most negative held", axisAWord, 16'hA000);
    step(1, 14'd8191, 0, 0, 0, 3'b000);
    chk("R3 +8191 smaller", axisAWord, 16'hA000);
  endtask

  task automatic t_mag();
    step(1, 0, 0, 14'd1000, 0, 3'b000);
    chk("R2 mag 1000", magWord, 16'h83E8);
    step(1, 0, 0, 14'd999, 0, 3'b000);
    chk("R2 mag 999 kept", magWord, 16'h83E8);
    step(1, 0, 0, 14'd16383, 0, 3'b000);
    chk("R2 mag full scale", magWord, 16'hBFFF);
  endtask

  task automatic t_read();
    step(0, 0, 0, 0, 0, 3'b001);
    chk("R10 A flag cleared",   axisAWord, 16'h2000);
    chk("R10 mag flag untouched", magWord, 16'hBFFF);
    chk("R10 B untouched",      axisBWord, 16'h3FCE);
    step(1, 0, -14'sd8000, 0, 0, 3'b010);
    chk("R7 update beats read", axisBWord, 16'hA0C0);
  endtask

  task automatic t_clear();
    step(1, 14'd7000, 14'd7000, 14'd7000, 1, 3'b000);
    chk("R6 axisA cleared", axisAWord, 16'h0000);
    chk("R6 axisB cleared", axisBWord, 16'h0000);
    chk("R6 mag cleared",   magWord,   16'h0000);
    step(1, 14'd3, 0, 0, 0, 3'b000);
    chk("R6 restart after clear", axisAWord, 16'h8003);
  endtask

  task automatic t_alarm();
    alarmIn = 1; #1;
    chk("R8 alarm on axisA", axisAWord, 16'hC003);
    chk("R8 alarm on mag",   magWord,   16'h4000);
    alarmIn = 0; #1;
    chk("R8 alarm off", axisAWord, 16'h8003);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_signed();
    t_tie();
    t_valid();
    t_mostneg();
    t_mag();
    t_read();
    t_clear();
    t_alarm();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule